// File: doc/BRIEF.md
# Hypercube Sum-and-Share Network

This block adds up one operand per node across a binary hypercube of `2^DIM` nodes and then hands the total back to every node. Nodes carry labels `0` to `2^DIM-1`. Each node is wired only to the `DIM` nodes whose labels differ from its own in one bit. A sequencer walks the dimensions one at a time, so each cycle uses one set of links.

The reduce phase steps through dimensions `0, 1, ..., DIM-1`. At the step for dimension `k`, every node whose low `k+1` label bits are all zero adds in the partial sum held by its neighbour across dimension `k`. After `DIM` steps node 0 holds the full total. The share phase then runs the same links backwards, through dimensions `DIM-1` down to `0`. At the step for dimension `k`, every node whose low `k+1` bits equal `1<<k` copies the value of its neighbour across dimension `k`. After `2*DIM` steps in all, every node holds the total.

A caller drives all operands in parallel on `load_data`, pulses `start`, waits for `done`, and then reads every node's copy of the total in parallel on `result`.

Top module: `hcube_reduce`

## Requirements
- R1: After reset, `busy` and `done` are 0 and every node value on `result` is 0.
- R2: A `start` seen at a clock edge while `busy` is 0 loads node `i` from `load_data[i*W +: W]` at that edge. In the cycle that follows, `busy` is 1 and `result` equals the loaded operands.
- R3: The reduce phase runs dimensions in ascending order, one per cycle. After the `DIM`-th step edge following the load, node 0 holds the sum of all operands.
- R4: After the `2*DIM`-th step edge following the load, every node slice of `result` holds the sum of all operands.
- R5: `done` rises exactly `2*DIM` edges after the load edge, in the same cycle that `busy` falls. `busy` and `done` are never 1 together.
- R6: A `start` pulse while `busy` is 1 is ignored. The data on `load_data` at that time does not enter the sum.
- R7: Sums are taken modulo `2^W`. A carry out of the top bit is dropped.
- R8: While idle, `result` and `done` stay unchanged until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sum-and-share run (accepted only when idle) |
| load_data | input | 2^DIM*W | Operands, node i in bits [i*W +: W] |
| result | output | 2^DIM*W | Node values, node i in bits [i*W +: W] |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has completed; held until the next start |

## Verification
The bench runs one instance each for `DIM` = 1, 2, 3 and 4.

Corner cases:
- **All-ones operands.** These force a wrap of the sum. A design that widened or saturated the sum would show the wrong total here.
- **Lone operand in the top-labelled node.** It must travel across every dimension. A sequencer that skipped or repeated a dimension would leave node 0 short, or double the value.
- **Node 0 probed at the reduce/share midpoint.** This catches a reduce phase run in the wrong dimension order.
- **`start` pulsed mid-run with different data.** A design that re-loaded on it would report a sum of the intruding operands.
- **Idle cycles after completion.** These expose a `done` flag or node values that drift once the run ends.

// File: rtl/hcube_pkg.sv
package hcube_pkg;

  // A node receives during the reduce step for dimension k when its low k+1 label bits are zero.
  function automatic logic rx_reduce(input int id, input int k);
    return (id & ((2 << k) - 1)) == 0;
  endfunction

  // A node receives during the share step for dimension k when its low k+1 bits equal 1<<k.
  function automatic logic rx_share(input int id, input int k);
    return (id & ((2 << k) - 1)) == (1 << k);
  endfunction

  // Neighbour across dimension k.
  function automatic int link_peer(input int id, input int k);
    return id ^ (1 << k);
  endfunction

endpackage

// File: rtl/hcube_seq.sv
module hcube_seq #(
  parameter int DIM = 3,
  localparam int DW = (DIM > 1) ? $clog2(DIM) : 1,
  localparam int SW = $clog2(2 * DIM) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          load,
  output logic          red_en,
  output logic          shr_en,
  output logic [DW-1:0] dim,
  output logic          last_step,
  output logic          busy,
  output logic          done
);

  localparam logic [SW-1:0] LAST = SW'(2 * DIM - 1);
  localparam logic [SW-1:0] HALF = SW'(DIM);

  logic [SW-1:0] step;

  assign load      = start && !busy;
  assign last_step = busy && (step == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      step <= '0;
    end else if (load) begin
      busy <= 1'b1;
      done <= 1'b0;
      step <= '0;
    end else if (busy) begin
      if (step == LAST) begin
        busy <= 1'b0;
        done <= 1'b1;
        step <= '0;
      end else begin
        step <= step + 1'b1;
      end
    end
  end

  always_comb begin
    red_en = busy && (step < HALF);
    shr_en = busy && (step >= HALF);
    if (step < HALF) dim = DW'(step);
    else             dim = DW'(LAST - step);
  end

  p_busy_done_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  p_done_after_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(last_step));
  p_run_not_cut_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_step) |=> busy);

endmodule

// File: rtl/hcube_node.sv
module hcube_node #(
  parameter int DIM = 3,
  parameter int W   = 16,
  parameter int ID  = 0,
  localparam int DW = (DIM > 1) ? $clog2(DIM) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [W-1:0]    operand,
  input  logic            red_en,
  input  logic            shr_en,
  input  logic [DW-1:0]   dim,
  input  logic [DIM*W-1:0] nbr,
  output logic [W-1:0]    val
);
  import hcube_pkg::*;

  logic [W-1:0] peer_val;
  logic         take_sum;
  logic         take_copy;

  assign peer_val  = nbr[int'(dim)*W +: W];
  assign take_sum  = red_en && rx_reduce(ID, int'(dim));
  assign take_copy = shr_en && rx_share(ID, int'(dim));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         val <= '0;
    else if (load)      val <= operand;
    else if (take_sum)  val <= val + peer_val;
    else if (take_copy) val <= peer_val;
  end

  p_single_action_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_sum && take_copy));

endmodule

// File: rtl/hcube_reduce.sv
module hcube_reduce #(
  parameter int DIM = 3,
  parameter int W   = 16,
  localparam int N  = 1 << DIM,
  localparam int DW = (DIM > 1) ? $clog2(DIM) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N*W-1:0] load_data,
  output logic [N*W-1:0] result,
  output logic           busy,
  output logic           done
);
  import hcube_pkg::*;

  logic          load;
  logic          red_en;
  logic          shr_en;
  logic [DW-1:0] dim;
  logic          last_step;
  logic [W-1:0]  node_val [N];

  hcube_seq #(.DIM(DIM)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .load(load),
    .red_en(red_en), .shr_en(shr_en), .dim(dim),
    .last_step(last_step), .busy(busy), .done(done)
  );

  for (genvar i = 0; i < N; i++) begin : g_node
    logic [DIM*W-1:0] nbr;
    for (genvar k = 0; k < DIM; k++) begin : g_link
      assign nbr[k*W +: W] = node_val[link_peer(i, k)];
    end
    hcube_node #(.DIM(DIM), .W(W), .ID(i)) node_i (
      .clk(clk), .rst_n(rst_n), .load(load),
      .operand(load_data[i*W +: W]),
      .red_en(red_en), .shr_en(shr_en), .dim(dim),
      .nbr(nbr), .val(node_val[i])
    );
    assign result[i*W +: W] = node_val[i];
  end

  logic all_same;
  always_comb begin
    all_same = 1'b1;
    for (int i = 1; i < N; i++)
      if (node_val[i] != node_val[0]) all_same = 1'b0;
  end

  p_load_takes_ops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && result == $past(load_data)));
  p_all_nodes_agree_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> all_same);
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(result) && $stable(done)));

endmodule

// File: tb/hcube_reduce_tb_top.sv
module hcube_unit_tb #(
  parameter int DIM = 1,
  parameter int W   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  output int          n_chk,
  output int          n_err,
  output logic        fin
);
  localparam int N = 1 << DIM;

  logic           start;
  logic [N*W-1:0] load_data;
  logic [N*W-1:0] result;
  logic           busy;
  logic           done;

  hcube_reduce #(.DIM(DIM), .W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .load_data(load_data),
    .result(result), .busy(busy), .done(done)
  );

  function automatic logic [W-1:0] ref_total(input logic [N*W-1:0] ops);
    logic [63:0] acc = 0;
    for (int i = 0; i < N; i++) acc += 64'(ops[i*W +: W]);
    return acc[W-1:0];
  endfunction

  function automatic logic [W-1:0] node_of(input logic [N*W-1:0] v, input int i);
    return v[i*W +: W];
  endfunction

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL DIM=%0d %s actual=%0h expected=%0h", DIM, req, act, exp);
    end
  endtask

  // One full run; intrude != 0 pulses start with other data mid-run (R6).
  task automatic run_case(input logic [N*W-1:0] ops, input logic intrude, input string tag);
    logic [W-1:0] tot = ref_total(ops);
    logic [N*W-1:0] snap;
    @(negedge clk);
    load_data = ops;
    start = 1'b1;
    @(negedge clk);          // after load edge
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", longint'(busy), 1);
    chk(result == ops, "R2 operands loaded", longint'(node_of(result, N-1)), longint'(node_of(ops, N-1)));
    for (int s = 1; s <= 2 * DIM; s++) begin
      if (intrude && s == 1) begin
        load_data = ~ops;
        start = 1'b1;
      end
      @(negedge clk);        // after step edge s
      start = 1'b0;
      if (s == DIM)
        chk(node_of(result, 0) == tot, {"R3 node0 total at midpoint ", tag},
            longint'(node_of(result, 0)), longint'(tot));
      if (s < 2 * DIM)
        chk(done == 1'b0 && busy == 1'b1, "R5 still running", longint'({busy, done}), 2);
    end
    chk(done == 1'b1 && busy == 1'b0, "R5 done at step 2*DIM", longint'({busy, done}), 1);
    for (int i = 0; i < N; i++)
      chk(node_of(result, i) == tot, intrude ? "R6 intruding start ignored" : {"R4 node total ", tag},
          longint'(node_of(result, i)), longint'(tot));
    snap = result;
    load_data = ~ops;
    repeat (3) @(negedge clk);
    chk(result == snap && done == 1'b1, "R8 idle hold", longint'(node_of(result, 0)), longint'(node_of(snap, 0)));
  endtask

  initial begin
    logic [N*W-1:0] ops;
    n_chk = 0;
    n_err = 0;
    fin = 1'b0;
    start = 1'b0;
    load_data = '0;
    void'($urandom(32'h1234 + DIM));
    @(posedge rst_n);
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 reset flags", longint'({busy, done}), 0);
    chk(result == '0, "R1 reset nodes", longint'(node_of(result, 0)), 0);

    ops = '1;
    run_case(ops, 1'b0, "all ones");
    chk(node_of(result, 0) == W'(N * ((1 << W) - 1)), "R7 modulo wrap",
        longint'(node_of(result, 0)), longint'(W'(N * ((1 << W) - 1))));

    ops = '0;
    ops[(N-1)*W +: W] = W'(16'h00a5);
    run_case(ops, 1'b0, "top node only");

    ops = '0;
    run_case(ops, 1'b0, "zeros");

    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < N; i++) ops[i*W +: W] = W'($urandom);
      run_case(ops, 1'b0, "random");
    end

    for (int i = 0; i < N; i++) ops[i*W +: W] = W'($urandom);
    run_case(ops, 1'b1, "intrude");

    fin = 1'b1;
  end

endmodule

module hcube_reduce_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   c1, c2, c3, c4, e1, e2, e3, e4;
  logic f1, f2, f3, f4;

  always #4 clk = ~clk;   // 125 MHz

  hcube_unit_tb #(.DIM(1)) u1 (.clk(clk), .rst_n(rst_n), .n_chk(c1), .n_err(e1), .fin(f1));
  hcube_unit_tb #(.DIM(2)) u2 (.clk(clk), .rst_n(rst_n), .n_chk(c2), .n_err(e2), .fin(f2));
  hcube_unit_tb #(.DIM(3)) u3 (.clk(clk), .rst_n(rst_n), .n_chk(c3), .n_err(e3), .fin(f3));
  hcube_unit_tb #(.DIM(4)) u4 (.clk(clk), .rst_n(rst_n), .n_chk(c4), .n_err(e4), .fin(f4));

  initial begin
    int cycles = 0;
    int wd_err = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    while (!(f1 && f2 && f3 && f4) && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!(f1 && f2 && f3 && f4)) begin
      wd_err = 1;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
    end
    $display("CHECKS %0d ERRORS %0d", c1 + c2 + c3 + c4 + wd_err,
             e1 + e2 + e3 + e4 + wd_err);
    $finish;
  end

endmodule